// File: doc/BRIEF.md
# Inverting Memory-Mapped Port Bank

This block sits on a small synchronous CPU bus and exposes four byte-wide ports through a window of eight register locations. Only the three least significant address bits select a location. Two of the ports are external inputs that the CPU reads. The other two are latched outputs that the CPU writes and that then drive pins.

Each port has its own data polarity. Both input ports return the bitwise complement of their pins. The first output port drives the complement of the written byte. The second output port complements bits 7 down to 2 and passes bits 1 and 0 through unchanged.

An access takes place only in a clock cycle where chip select is high together with the read strobe or the write strobe. Read data is combinational and valid during the strobed cycle. Written data appears on the output pins from the clock edge that ends the write cycle.

Top module: `port_bank`

## Requirements
- R1: After reset, and before any write, `pb_out` and `pc_out` are both 00H.
- R2: A read access (`cs`=1, `rd`=1) at location 0 places `~pa_in` on `dout` in the same cycle.
- R3: A read access at location 1 places `~in_bus` on `dout` in the same cycle.
- R4: A write access (`cs`=1, `wr`=1) at location 0 sets `pb_out` to `~din`, starting with the cycle after the write.
- R5: A write access at location 1 sets `pc_out` to `{~din[7:2], din[1:0]}`, starting with the cycle after the write.
- R6: Both output ports hold their value when there is no write to their location. This includes writes made with `cs`=0 and writes to locations 2 through 7.
- R7: `dout` is 00H on a read access to locations 2 through 7, and in every cycle without a read access, which includes `rd`=1 with `cs`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| addr | input | 3 | Location select (bits 2..0) |
| din | input | 8 | Write data from the CPU |
| dout | output | 8 | Read data to the CPU |
| pa_in | input | 8 | Input port A pins |
| in_bus | input | 8 | Input port IN pins |
| pb_out | output | 8 | Output port B pins |
| pc_out | output | 8 | Output port C pins |

## Verification
Several properties are checked on every cycle:
- the polarity on each write path, including the mixed mask of port C;
- that both output registers hold their value whenever their location is not written;
- that the read mux returns the complement of each input port, and zero on every other read.

Only the bench sweeps show some of the behaviour:
- that every one of the 256 byte values survives each path;
- that reset leaves the pins low;
- that an output port still holds its last value after a long run of unrelated writes and reads.

// File: rtl/port_bank.sv
module port_bank #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter logic [DW-1:0] PC_PASS = 8'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] pa_in,
  input  logic [DW-1:0] in_bus,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pc_out
);

  localparam logic [AW-1:0] LOC_AB  = AW'(0);
  localparam logic [AW-1:0] LOC_INC = AW'(1);

  logic rd_acc, wr_acc;
  logic [DW-1:0] pb_q, pc_q;

  assign rd_acc = cs & rd;
  assign wr_acc = cs & wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_q <= '0;
      pc_q <= '0;
    end else if (wr_acc) begin
      if (addr == LOC_AB)  pb_q <= ~din;
      if (addr == LOC_INC) pc_q <= din ^ ~PC_PASS;
    end
  end

  always_comb begin
    dout = '0;
    if (rd_acc) begin
      case (addr)
        LOC_AB:  dout = ~pa_in;
        LOC_INC: dout = ~in_bus;
        default: dout = '0;
      endcase
    end
  end

  assign pb_out = pb_q;
  assign pc_out = pc_q;

  assert_pb_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == LOC_AB) |=> (pb_out == ~$past(din)));

  assert_pc_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == LOC_INC) |=>
      (pc_out[DW-1:2] == ~$past(din[DW-1:2]) && pc_out[1:0] == $past(din[1:0])));

  assert_pb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr && addr == LOC_AB) |=> $stable(pb_out));

  assert_pc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr && addr == LOC_INC) |=> $stable(pc_out));

  assert_pa_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == LOC_AB) |-> (dout == ~pa_in));

  assert_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == LOC_INC) |-> (dout == ~in_bus));

  assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs && rd) || addr > LOC_INC) |-> (dout == '0));

endmodule

// File: tb/port_bank_tb.sv
module port_bank_tb;
  logic clk = 0, rst_n = 0, cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] din = '0, pa_in = '0, in_bus = '0;
  logic [7:0] dout, pb_out, pc_out;
  int n_chk = 0, n_bad = 0;
  logic [7:0] b_exp = 8'h00, c_exp = 8'h00;

  always #10 clk = ~clk;

  port_bank u_dut (.clk, .rst_n, .cs, .rd, .wr, .addr, .din, .dout,
                   .pa_in, .in_bus, .pb_out, .pc_out);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic c, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cs = c; wr = 1; addr = a; din = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic bus_rd(logic c, logic [2:0] a, output logic [7:0] q);
    @(negedge clk);
    cs = c; rd = 1; addr = a;
    #2 q = dout;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got 00 expected 01");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pb", pb_out, 8'h00);
    chk("R1 pc", pc_out, 8'h00);
    chk("R7 idle", dout, 8'h00);

    for (int v = 0; v < 256; v++) begin
      bus_wr(1, 3'd0, 8'(v));
      b_exp = ~8'(v);
      chk("R4", pb_out, b_exp);
      chk("R6 pc", pc_out, c_exp);
    end
    for (int v = 0; v < 256; v++) begin
      bus_wr(1, 3'd1, 8'(v));
      c_exp = {~v[7:2], v[1:0]};
      chk("R5", pc_out, c_exp);
      chk("R6 pb", pb_out, b_exp);
    end

    for (int v = 0; v < 256; v++) begin
      pa_in = 8'(v); in_bus = 8'(255 - v);
      bus_rd(1, 3'd0, q);
      chk("R2", q, ~8'(v));
      bus_rd(1, 3'd1, q);
      chk("R3", q, 8'(v));
    end

    for (int a = 2; a < 8; a++) begin
      for (int v = 0; v < 256; v += 51) begin
        pa_in = 8'(v); in_bus = 8'(v);
        bus_rd(1, 3'(a), q);
        chk("R7 unused", q, 8'h00);
        bus_wr(1, 3'(a), 8'(v));
        chk("R6 unused pb", pb_out, b_exp);
        chk("R6 unused pc", pc_out, c_exp);
      end
    end

    for (int a = 0; a < 2; a++) begin
      for (int v = 0; v < 256; v += 17) begin
        pa_in = 8'(v); in_bus = 8'(v);
        bus_rd(0, 3'(a), q);
        chk("R7 no cs", q, 8'h00);
        bus_wr(0, 3'(a), 8'(v));
        chk("R6 no cs pb", pb_out, b_exp);
        chk("R6 no cs pc", pc_out, c_exp);
      end
    end

    bus_wr(1, 3'd0, 8'h5A);
    b_exp = 8'hA5;
    repeat (20) @(negedge clk);
    chk("R6 long hold pb", pb_out, b_exp);
    chk("R6 long hold pc", pc_out, c_exp);

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 re-reset pb", pb_out, 8'h00);
    chk("R1 re-reset pc", pc_out, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule